// File: doc/BRIEF.md
# Segmented Backup Compression Scheduler

This block coordinates a set of parallel compression engines during a state backup. The wide state vector is cut into M segments, and each segment has its own engine. The upper S segments are "shared" segments. Each shared segment has a private slice that always stays with its home engine, and a handover slice that a multiplexer can route to a different engine. When a backup request arrives, the scheduler starts every engine at once. It then watches which engines are busy and how much work each shared segment still has. As soon as some engine goes idle while a shared segment is still working, the scheduler hands that segment's handover slice to the idle engine.

The multiplexer select for each handover slice doubles as a holder tag. It keeps pointing at the engine that compressed the slice until the next backup starts, so a later restore can read the slice back from the correct place. When every engine has drained, the scheduler raises a single-cycle completion pulse and waits for the next request.

Top module: `spc_sched`

## Requirements
- R1: A start request sampled while the scheduler is idle produces, in the next cycle, a one-cycle kick on all M engines (kick all ones), and every holder tag returns to its home engine index.
- R2: A start request sampled while a backup is in progress has no effect: no kick of all engines follows, and the tags and the schedule continue unchanged.
- R3: An engine counts as free only when its busy input is low and it was not kicked in the current cycle, so an engine that has just been kicked is never handed work before its busy flag can rise.
- R4: A shared segment is eligible for handover only while its home engine is busy, its remaining-work count is nonzero, and its slice has not yet been moved in this backup.
- R5: Among the eligible shared segments, the one with the largest remaining-work count is chosen, and a tie goes to the lowest shared segment index.
- R6: When an eligible segment and a free engine both exist, the lowest-indexed free engine receives the slice and sees a one-hot kick in the next cycle. At most one handover happens per cycle.
- R7: Each handover slice moves at most once per backup, and once moved its tag stays fixed until the next backup starts.
- R8: The tag of shared segment s is field s of partSel, TW bits wide (TW = clog2 M), and holds the index of the engine that owns the slice. The home engine of shared segment s is M-S+s. The tag persists after completion.
- R9: When all engines are free and no handover is possible, allDone pulses high for exactly one cycle in the next cycle, with no kick, and the scheduler returns to idle.
- R10: After reset, kick and allDone are low, every tag holds its home index, and the scheduler is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| startReq | input | 1 | Backup request |
| engBusy | input | M | Busy flag per compression engine |
| segRemain | input | S*RW | Remaining-work count per shared segment; zero once its slice can no longer be handed over |
| kick | output | M | One-cycle start strobe per engine |
| partSel | output | S*TW | Multiplexer select / holder tag per handover slice |
| allDone | output | 1 | One-cycle completion pulse |

## Verification
The hardest situations to create are two shared segments with equal remaining counts while an engine frees up, and an engine that has just finished a borrowed slice becoming free again while another segment is still eligible. The bench drives cycle-accurate engine models from a sweep of segment lengths. These lengths include equal private and handover sizes, which force ties, and short fixed segments, which free engines early and repeatedly. A reference scheduler, built from the requirements and run in lockstep, predicts every kick, every tag and the completion pulse. Each run also raises a second start request in mid-backup.

// File: rtl/spc_pkg.sv
package spc_pkg;
  // strobes issued by the control FSM to the datapath
  typedef struct packed {
    logic clear;    // new backup: reset tags and moved flags
    logic kickAll;  // start every engine
    logic move;     // hand the picked slice to the picked engine
    logic finish;   // raise the completion pulse
  } spc_strobe_t;
endpackage

// File: rtl/spc_ctrl.sv
module spc_ctrl
  import spc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        haveCand,
  input  logic        haveIdle,
  input  logic        allAvail,
  output spc_strobe_t strb,
  output logic        running
);
  typedef enum logic {ST_IDLE, ST_RUN} state_t;
  state_t st, stN;

  always_comb begin
    strb = '0;
    stN  = st;
    case (st)
      ST_IDLE: begin
        if (startReq) begin
          strb.clear   = 1'b1;
          strb.kickAll = 1'b1;
          stN          = ST_RUN;
        end
      end
      ST_RUN: begin
        // a handover always takes precedence over completion
        if (haveCand && haveIdle) begin
          strb.move = 1'b1;
        end else if (allAvail) begin
          strb.finish = 1'b1;
          stN         = ST_IDLE;
        end
      end
      default: stN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= stN;
  end

  assign running = (st == ST_RUN);
endmodule

// File: rtl/spc_dp.sv
module spc_dp
  import spc_pkg::*;
#(
  parameter int M  = 5,
  parameter int S  = 2,
  parameter int RW = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  spc_strobe_t       strb,
  input  logic [M-1:0]      engBusy,
  input  logic [S*RW-1:0]   segRemain,
  output logic              haveCand,
  output logic              haveIdle,
  output logic              allAvail,
  output logic [M-1:0]      kick,
  output logic [S*((M>1)?$clog2(M):1)-1:0] partSel,
  output logic              allDone
);
  localparam int TW   = (M > 1) ? $clog2(M) : 1;
  localparam int SW   = (S > 1) ? $clog2(S) : 1;
  localparam int HOME = M - S;

  logic [TW-1:0] owner [S];
  logic [S-1:0]  moved;
  logic [M-1:0]  kickQ, kickN, avail;
  logic          doneQ;
  logic [SW-1:0] candIdx;
  logic [RW-1:0] bestRem;
  logic [TW-1:0] idleIdx;

  // an engine kicked this cycle has not had the chance to raise busy
  assign avail    = ~engBusy & ~kickQ;
  assign allAvail = &avail;

  // largest remaining work wins; strict compare keeps the lowest index on a tie
  always_comb begin
    haveCand = 1'b0;
    candIdx  = '0;
    bestRem  = '0;
    for (int s = 0; s < S; s++) begin
      if (!moved[s] && (segRemain[s*RW +: RW] != '0) && engBusy[HOME+s] &&
          (!haveCand || (segRemain[s*RW +: RW] > bestRem))) begin
        haveCand = 1'b1;
        candIdx  = SW'(s);
        bestRem  = segRemain[s*RW +: RW];
      end
    end
  end

  // lowest free engine: scan downward so the last hit is the lowest index
  always_comb begin
    haveIdle = 1'b0;
    idleIdx  = '0;
    for (int i = M - 1; i >= 0; i--) begin
      if (avail[i]) begin
        haveIdle = 1'b1;
        idleIdx  = TW'(i);
      end
    end
  end

  always_comb begin
    kickN = '0;
    if (strb.kickAll)   kickN = '1;
    else if (strb.move) kickN[idleIdx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kickQ <= '0;
      doneQ <= 1'b0;
      moved <= '0;
      for (int s = 0; s < S; s++) owner[s] <= TW'(HOME + s);
    end else begin
      kickQ <= kickN;
      doneQ <= strb.finish;
      if (strb.clear) begin
        moved <= '0;
        for (int s = 0; s < S; s++) owner[s] <= TW'(HOME + s);
      end else if (strb.move) begin
        owner[candIdx] <= idleIdx;
        moved[candIdx] <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < S; g++) begin : g_tag
    assign partSel[g*TW +: TW] = owner[g];
  end

  assign kick    = kickQ;
  assign allDone = doneQ;
endmodule

// File: rtl/spc_sched.sv
module spc_sched
  import spc_pkg::*;
#(
  parameter int M  = 5,
  parameter int S  = 2,
  parameter int RW = 10
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startReq,
  input  logic [M-1:0]    engBusy,
  input  logic [S*RW-1:0] segRemain,
  output logic [M-1:0]    kick,
  output logic [S*((M>1)?$clog2(M):1)-1:0] partSel,
  output logic            allDone
);
  spc_strobe_t strb;
  logic running, haveCand, haveIdle, allAvail;

  spc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .haveCand(haveCand), .haveIdle(haveIdle), .allAvail(allAvail),
    .strb(strb), .running(running)
  );

  spc_dp #(.M(M), .S(S), .RW(RW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .engBusy(engBusy), .segRemain(segRemain),
    .haveCand(haveCand), .haveIdle(haveIdle), .allAvail(allAvail),
    .kick(kick), .partSel(partSel), .allDone(allDone)
  );
endmodule

// File: rtl/spc_sched_chk.sv
module spc_sched_chk #(
  parameter int M = 5,
  parameter int S = 2
) (
  input logic         clk,
  input logic         rstN,
  input logic         startReq,
  input logic         running,
  input logic [M-1:0] engBusy,
  input logic [M-1:0] kick,
  input logic [S*((M>1)?$clog2(M):1)-1:0] partSel,
  input logic         allDone
);
  localparam int TW = (M > 1) ? $clog2(M) : 1;

  p_start_kicks_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!running && startReq) |=> (kick == {M{1'b1}}));

  p_start_ignored_r2: assert property (@(posedge clk) disable iff (!rstN)
    (running && startReq) |=> (kick != {M{1'b1}}));

  p_single_grant_r6: assert property (@(posedge clk) disable iff (!rstN)
    (kick != {M{1'b1}}) |-> $onehot0(kick));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    allDone |=> !allDone);

  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    allDone |-> (kick == '0));

  for (genvar i = 0; i < M; i++) begin : g_eng
    p_grant_free_r3: assert property (@(posedge clk) disable iff (!rstN)
      (kick[i] && (kick != {M{1'b1}})) |-> ($past(!engBusy[i]) && $past(!kick[i])));
  end

  for (genvar g = 0; g < S; g++) begin : g_seg
    localparam logic [TW-1:0] HT = TW'(M - S + g);
    p_tag_frozen_r7: assert property (@(posedge clk) disable iff (!rstN)
      (running && (partSel[g*TW +: TW] != HT)) |=> $stable(partSel[g*TW +: TW]));
  end
endmodule

bind spc_sched spc_sched_chk #(.M(M), .S(S)) u_chk (
  .clk(clk), .rstN(rstN), .startReq(startReq), .running(running),
  .engBusy(engBusy), .kick(kick), .partSel(partSel), .allDone(allDone)
);

// File: tb/spc_sched_bench.sv
`timescale 1ns/1ps
module spc_sched_bench;
  localparam int M = 4, S = 2, RW = 8, TW = 2, HOME = M - S;

  logic clk = 1'b0, rstN = 1'b0, startReq = 1'b0;
  logic [M-1:0] engBusy = '0;
  logic [S*RW-1:0] segRemain = '0;
  logic [M-1:0] kick;
  logic [S*TW-1:0] partSel;
  logic allDone;

  always #2.5 clk = ~clk;

  spc_sched #(.M(M), .S(S), .RW(RW)) u_spc_sched (
    .clk(clk), .rstN(rstN), .startReq(startReq), .engBusy(engBusy),
    .segRemain(segRemain), .kick(kick), .partSel(partSel), .allDone(allDone)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  // engine models
  int cnt[M];
  int lenFix[HOME];
  int pLen[S], qLen[S];
  bit gone[S];
  // reference scheduler
  bit mRun, mMoved[S];
  int mOwner[S];
  logic [M-1:0] expKick;
  bit expDone;
  int moveSeg;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive_inputs();
    for (int i = 0; i < M; i++) engBusy[i] = (cnt[i] > 0);
    for (int s = 0; s < S; s++)
      segRemain[s*RW +: RW] = (!gone[s] && cnt[HOME+s] > qLen[s]) ? RW'(cnt[HOME+s]) : '0;
  endtask

  task automatic compare_all();
    chk(kick === expKick, "R1 R2 R3 R6 kick", int'(kick), int'(expKick));
    for (int s = 0; s < S; s++)
      chk(partSel[s*TW +: TW] === TW'(mOwner[s]), "R4 R5 R7 R8 tag",
          int'(partSel[s*TW +: TW]), mOwner[s]);
    chk(allDone === expDone, "R9 allDone", int'(allDone), int'(expDone));
  endtask

  task automatic step(input bit st);
    logic [M-1:0] avail;
    int c, e, best;
    startReq = st;
    avail = ~engBusy & ~expKick;
    moveSeg = -1;
    if (!mRun) begin
      expKick = '0;
      expDone = 0;
      if (st) begin
        mRun = 1;
        expKick = '1;
        for (int s = 0; s < S; s++) begin mOwner[s] = HOME + s; mMoved[s] = 0; end
      end
    end else begin
      c = -1; best = 0; e = -1;
      for (int s = 0; s < S; s++) begin
        int r;
        r = int'(segRemain[s*RW +: RW]);
        if (!mMoved[s] && r != 0 && engBusy[HOME+s] && (c < 0 || r > best)) begin
          c = s; best = r;
        end
      end
      for (int i = M - 1; i >= 0; i--) if (avail[i]) e = i;
      expKick = '0;
      expDone = 0;
      if (c >= 0 && e >= 0) begin
        mOwner[c] = e; mMoved[c] = 1; expKick[e] = 1'b1; moveSeg = c;
      end else if (&avail) begin
        expDone = 1; mRun = 0;
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare_all();
    // engines react to the kick now visible
    if (expKick == '1) begin
      for (int i = 0; i < M; i++) cnt[i] = (i < HOME) ? lenFix[i] : pLen[i-HOME] + qLen[i-HOME];
      for (int s = 0; s < S; s++) gone[s] = 0;
    end else begin
      for (int i = 0; i < M; i++) begin
        if (moveSeg >= 0 && i == HOME + moveSeg) cnt[i] -= qLen[moveSeg];
        if (expKick[i]) cnt[i] = qLen[moveSeg];
        else if (cnt[i] > 0) cnt[i]--;
      end
      if (moveSeg >= 0) gone[moveSeg] = 1;
    end
    drive_inputs();
    startReq = 1'b0;
  endtask

  task automatic run_case(input int l0, input int l1, input int p2, input int p3,
                          input int q2, input int q3);
    int k;
    lenFix[0] = l0; lenFix[1] = l1;
    pLen[0] = p2; pLen[1] = p3; qLen[0] = q2; qLen[1] = q3;
    step(1'b1);
    k = 1;
    // R2: a second request in mid-backup must be ignored
    while (mRun && k < 200) begin
      step(k == 3);
      k++;
    end
    chk(!mRun, "R9 completion reached", int'(mRun), 0);
    step(1'b0);
    step(1'b0);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int fixVals[3] = '{1, 3, 6};
    int pVals[2] = '{1, 4};
    int qVals[2] = '{2, 5};
    for (int i = 0; i < M; i++) cnt[i] = 0;
    for (int s = 0; s < S; s++) begin
      gone[s] = 0; mOwner[s] = HOME + s; mMoved[s] = 0; qLen[s] = 0; pLen[s] = 0;
    end
    mRun = 0; expKick = '0; expDone = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(kick == '0, "R10 kick after reset", int'(kick), 0);
    chk(allDone == 1'b0, "R10 allDone after reset", int'(allDone), 0);
    for (int s = 0; s < S; s++)
      chk(partSel[s*TW +: TW] == TW'(HOME + s), "R10 tag after reset",
          int'(partSel[s*TW +: TW]), HOME + s);
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int c = 0; c < 2; c++)
          for (int d = 0; d < 2; d++)
            for (int x = 0; x < 2; x++)
              for (int y = 0; y < 2; y++)
                run_case(fixVals[a], fixVals[b], pVals[c], pVals[d], qVals[x], qVals[y]);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule